// File: doc/BRIEF.md
# Ping-pong FFT input frame loader

This block sits in front of an in-place FFT engine. A data-source host pushes complex samples (real and imaginary parts in two's complement, presented together) into one of two identical frame banks. The other bank is on loan to the engine as working memory. Each bank holds `FRAME_N` complex words and is built from two half-size memories. Samples with an even frame index go to one half and samples with an odd index go to the other, so the engine can fetch two samples per clock.

The host watches `load_rdy` and marks each transferred sample with `in_valid`. It may leave any number of idle cycles between samples. When the last sample of a frame lands, the block pulses `frame_full` and stops accepting data. The block hands the full bank to the engine only when the engine is idle or reports `eng_done` in that cycle. The block then reopens the other bank for loading. `eng_bank` shows when the engine is working in the second bank. A synchronous `start` pulse or the asynchronous reset throws away any partial frame and any handover in progress. A registered read port gives the engine, or a test, access to any word of either bank.

Top module: `fftld_frame_loader`

## Requirements
- R1: After the active-low asynchronous reset, `load_rdy` is 1 and `eng_bank` and `frame_full` are 0. The first accepted sample is stored as frame index 0 in bank 0.
- R2: Each clock edge with `in_valid`=1, `load_rdy`=1 and `start`=0 stores exactly one sample at the next frame index. Idle cycles between samples do not advance the index.
- R3: `load_rdy` is 0 from the cycle after the `FRAME_N`-th sample is stored until a bank swap. While it is 0, `in_valid` and the data inputs change no stored word and do not advance the index.
- R4: A sample with frame index k goes to the bank being filled, to half k[0] (0 = even half, 1 = odd half), at word address k>>1. The other bank is not written.
- R5: A swap happens only at an edge where the filling bank is full and the engine is either idle or asserts `eng_done` in that cycle. `load_rdy` is 1 again in the cycle after the swap edge.
- R6: `eng_bank` is 1 exactly while the engine owns bank 1 (rd_bank=1). It is 0 while the engine is idle or owns bank 0.
- R7: `start`=1 at an edge discards any partial frame and any engine ownership. Afterwards `load_rdy`=1, `eng_bank`=0, and the next sample is stored as index 0 of bank 0.
- R8: `frame_full` is high for exactly the one cycle after the edge that stores the `FRAME_N`-th sample of a frame.
- R9: The read port returns the word selected by `rd_bank`, `rd_half` and `rd_addr` one cycle after the address is presented, as {`rd_re`, `rd_im`}.
- R10: `eng_done` while the engine is idle has no effect on `load_rdy`, `eng_bank` or the next swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous discard and return to ready-to-load |
| in_valid | input | 1 | A sample is present on the data inputs |
| in_re | input | SAMP_W | Real part, two's complement |
| in_im | input | SAMP_W | Imaginary part, two's complement |
| load_rdy | output | 1 | Filling bank accepts samples |
| frame_full | output | 1 | One-cycle pulse after a frame completes |
| eng_done | input | 1 | Engine finished its current frame |
| eng_bank | output | 1 | Engine is working in bank 1 |
| rd_bank | input | 1 | Read port bank select |
| rd_half | input | 1 | Read port half select (0 even, 1 odd) |
| rd_addr | input | $clog2(FRAME_N)-1 | Read port word address |
| rd_re | output | SAMP_W | Read real part, one cycle latency |
| rd_im | output | SAMP_W | Read imaginary part, one cycle latency |

## Verification
Assertions check the following on every cycle. At most one half-memory is written per edge. The index steps by one per accepted sample. A full bank stays full and its index frozen until a swap or start. The fill bank changes only after a full frame or a start. `frame_full` is a lone pulse that coincides with the full state. Any swap leaves the engine busy. Only the bench's scenarios can show where each sample lands, through sweeps of complete frames read back word by word from both banks. They also cover a rejected sample under `load_rdy`=0, the handover that waits for `eng_done`, a discarded partial frame, and a stray `eng_done` while idle.

// File: rtl/fftld_pkg.sv
package fftld_pkg;

  typedef enum logic {
    BANK_PING = 1'b0,
    BANK_PONG = 1'b1
  } bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_PING) ? BANK_PONG : BANK_PING;
  endfunction

endpackage

// File: rtl/fftld_half_mem.sv
module fftld_half_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fftld_fill_ctrl.sv
module fftld_fill_ctrl #(
  parameter int FRAME_N = 32,
  localparam int IW     = $clog2(FRAME_N),
  localparam int AW     = IW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic          swap_go,
  output logic          wr_fire,
  output logic          wr_half,
  output logic [AW-1:0] wr_addr,
  output logic          full,
  output logic          frame_full
);

  logic [IW-1:0] ptr;
  logic          last;

  function automatic logic half_of(input logic [IW-1:0] k);
    return k[0];
  endfunction

  function automatic logic [AW-1:0] word_of(input logic [IW-1:0] k);
    return k[IW-1:1];
  endfunction

  assign last    = (ptr == IW'(FRAME_N - 1));
  assign wr_fire = in_valid && !full && !start;
  assign wr_half = half_of(ptr);
  assign wr_addr = word_of(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      full       <= 1'b0;
      frame_full <= 1'b0;
    end else if (start) begin
      ptr        <= '0;
      full       <= 1'b0;
      frame_full <= 1'b0;
    end else begin
      frame_full <= wr_fire && last;
      if (wr_fire) begin
        ptr <= last ? '0 : ptr + IW'(1);
        if (last) full <= 1'b1;
      end else if (swap_go) begin
        full <= 1'b0;
      end
    end
  end

  a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !last) |=> (ptr == $past(ptr) + IW'(1)));

  a_r3_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !swap_go && !start) |=> (full && $stable(ptr)));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_full |=> !frame_full);

  a_r8_pulse_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    frame_full |-> full);

endmodule

// File: rtl/fftld_bank_ctrl.sv
module fftld_bank_ctrl
  import fftld_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  full,
  input  logic  eng_done,
  output logic  swap_go,
  output bank_e fill_bank,
  output logic  eng_busy,
  output logic  eng_bank
);

  assign swap_go  = full && (!eng_busy || eng_done) && !start;
  assign eng_bank = eng_busy && (other_bank(fill_bank) == BANK_PONG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_bank <= BANK_PING;
      eng_busy  <= 1'b0;
    end else if (start) begin
      fill_bank <= BANK_PING;
      eng_busy  <= 1'b0;
    end else if (swap_go) begin
      fill_bank <= other_bank(fill_bank);
      eng_busy  <= 1'b1;
    end else if (eng_done) begin
      eng_busy  <= 1'b0;
    end
  end

  a_r5_flip_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fill_bank) |-> ($past(full) || $past(start)));

  a_r6_busy_after_swap: assert property (@(posedge clk) disable iff (!rst_n)
    swap_go |=> eng_busy);

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!eng_busy && fill_bank == BANK_PING));

endmodule

// File: rtl/fftld_frame_loader.sv
module fftld_frame_loader
  import fftld_pkg::*;
#(
  parameter int FRAME_N = 32,
  parameter int SAMP_W  = 8,
  localparam int IW     = $clog2(FRAME_N),
  localparam int AW     = IW - 1,
  localparam int HALF_N = FRAME_N / 2,
  localparam int DW     = 2 * SAMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_re,
  input  logic [SAMP_W-1:0] in_im,
  output logic              load_rdy,
  output logic              frame_full,
  input  logic              eng_done,
  output logic              eng_bank,
  input  logic              rd_bank,
  input  logic              rd_half,
  input  logic [AW-1:0]     rd_addr,
  output logic [SAMP_W-1:0] rd_re,
  output logic [SAMP_W-1:0] rd_im
);

  logic          wr_fire;
  logic          wr_half;
  logic [AW-1:0] wr_addr;
  logic          full;
  logic          swap_go;
  bank_e         fill_bank;
  logic          eng_busy;
  logic [3:0]    we_vec;
  logic [DW-1:0] rdata [4];
  logic [1:0]    rd_sel_q;

  fftld_fill_ctrl #(.FRAME_N(FRAME_N)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_valid   (in_valid),
    .swap_go    (swap_go),
    .wr_fire    (wr_fire),
    .wr_half    (wr_half),
    .wr_addr    (wr_addr),
    .full       (full),
    .frame_full (frame_full)
  );

  fftld_bank_ctrl u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .full      (full),
    .eng_done  (eng_done),
    .swap_go   (swap_go),
    .fill_bank (fill_bank),
    .eng_busy  (eng_busy),
    .eng_bank  (eng_bank)
  );

  assign load_rdy = !full;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar h = 0; h < 2; h++) begin : g_half
      assign we_vec[2*b+h] = wr_fire && (fill_bank == bank_e'(b)) && (wr_half == 1'(h));
      fftld_half_mem #(.DW(DW), .DEPTH(HALF_N)) u_mem (
        .clk   (clk),
        .we    (we_vec[2*b+h]),
        .waddr (wr_addr),
        .wdata ({in_re, in_im}),
        .raddr (rd_addr),
        .rdata (rdata[2*b+h])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_sel_q <= '0;
    else        rd_sel_q <= {rd_bank, rd_half};
  end

  assign {rd_re, rd_im} = rdata[rd_sel_q];

  a_r4_one_half_written: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  a_r3_no_write_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rdy |-> (we_vec == 4'b0000));

endmodule

// File: tb/sim_fftld_frame_loader.sv
module sim_fftld_frame_loader;

  localparam int N  = 32;
  localparam int W  = 8;
  localparam int AW = $clog2(N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_re = '0;
  logic [W-1:0] in_im = '0;
  logic load_rdy, frame_full, eng_bank;
  logic eng_done = 1'b0;
  logic rd_bank = 1'b0;
  logic rd_half = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0] rd_re, rd_im;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fftld_frame_loader #(.FRAME_N(N), .SAMP_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .load_rdy(load_rdy), .frame_full(frame_full),
    .eng_done(eng_done), .eng_bank(eng_bank), .rd_bank(rd_bank),
    .rd_half(rd_half), .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im)
  );

  function automatic logic [W-1:0] pat_re(input int fr, input int k);
    return W'(fr * 53 + k * 7 + 3);
  endfunction

  function automatic logic [W-1:0] pat_im(input int fr, input int k);
    return W'((fr * 29) ^ (k * 11 + 5));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] re, input logic [W-1:0] im, input int gap);
    in_valid = 1'b1; in_re = re; in_im = im;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_frame(input int fr, input int count, input bit gaps);
    for (int k = 0; k < count; k++)
      send(pat_re(fr, k), pat_im(fr, k), (gaps && k != count - 1) ? k % 3 : 0);
  endtask

  task automatic pulse_done();
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // R4 / R9: index k sits in half k[0] at word k>>1; data one cycle after address
  task automatic read_frame(input bit bank, input int fr, input string req);
    for (int k = 0; k < N; k++) begin
      rd_bank = bank; rd_half = k[0]; rd_addr = AW'(k >> 1);
      @(negedge clk);
      check(req, {rd_re, rd_im}, {pat_re(fr, k), pat_im(fr, k)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 load_rdy", load_rdy, 1);
    check("R1 eng_bank", eng_bank, 0);
    check("R1 frame_full", frame_full, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Frame 0 into bank 0 with idle gaps (R2)
    send_frame(0, N, 1);
    check("R8 pulse high", frame_full, 1);
    check("R3 load low", load_rdy, 0);
    @(negedge clk);
    check("R8 pulse one cycle", frame_full, 0);
    check("R5 reopen after idle swap", load_rdy, 1);
    check("R6 engine owns bank 0", eng_bank, 0);
    read_frame(1'b0, 0, "R4 R9 R1 R2 bank0 frame0");

    // Frame 1 into bank 1, back to back, engine still busy
    send_frame(1, N, 0);
    check("R8 pulse frame1", frame_full, 1);
    repeat (4) @(negedge clk);
    check("R5 wait for engine", load_rdy, 0);
    // R3: sample offered while closed is ignored
    send(8'hA5, 8'h5A, 0);
    check("R3 still closed", load_rdy, 0);
    pulse_done();
    check("R5 swap on done", load_rdy, 1);
    check("R6 engine owns bank 1", eng_bank, 1);
    read_frame(1'b1, 1, "R3 R4 bank1 frame1");

    // R7: partial frame then start
    send_frame(7, 5, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 load after start", load_rdy, 1);
    check("R7 eng_bank after start", eng_bank, 0);
    check("R7 frame_full after start", frame_full, 0);
    send_frame(2, N, 1);
    @(negedge clk);
    check("R5 idle swap frame2", load_rdy, 1);
    check("R6 engine owns bank 0 again", eng_bank, 0);
    read_frame(1'b0, 2, "R7 R4 bank0 frame2");

    // R10: done while idle has no effect
    pulse_done();
    pulse_done();
    check("R10 eng_bank", eng_bank, 0);
    check("R10 load_rdy", load_rdy, 1);
    send_frame(3, N, 0);
    check("R8 pulse frame3", frame_full, 1);
    @(negedge clk);
    check("R10 R5 immediate swap", load_rdy, 1);
    check("R6 bank1 busy", eng_bank, 1);
    read_frame(1'b1, 3, "R4 bank1 frame3");
    // R4: bank 0 untouched by frame 3
    rd_bank = 1'b0; rd_half = 1'b0; rd_addr = '0;
    @(negedge clk);
    check("R4 other bank kept", {rd_re, rd_im}, {pat_re(2, 0), pat_im(2, 0)});

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule